// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block divides a fast input clock by a programmable total ratio of M·N + A, using the pulse-swallow scheme. A synchronous model of a two-ratio prescaler divides the input clock by either M or M+1. Two down-counters count the prescaler's output cycles and decide which of the two ratios the prescaler uses next. The swallow counter starts at A and the main counter starts at N.

At the start of each output period the prescaler runs at M+1 for A of its cycles. It then runs at M for the remaining N−A prescaler cycles. When the main counter expires, both counters reload together and the block emits a single-cycle comparison pulse. A phase comparator elsewhere uses that pulse against the reference.

The main-count, swallow-count and modulus-select inputs are sampled only at that reload boundary. A driver can therefore change them at any time without cutting a period short. A main count below three is replaced by three for the whole period, and an error output is raised for that period.

Top module: `psw_divider`

## Requirements
- R1: The number of input-clock cycles from one rise of `fp_o` to the next equals M·N + A, where N is the main count (after clamping) and A is the swallow count in force for that period, provided A < N. This holds at the boundaries A=0, A=N−1, N=3 and N=2047.
- R2: M is `M_LO` when `mod_sel_i` is 1 and `M_HI` when `mod_sel_i` is 0. The defaults are 64 and 128.
- R3: Within each period, `mod_ctl_o` is 1 for exactly A·(M+1) input cycles. Those cycles start at the cycle in which `fp_o` is 1, and `mod_ctl_o` can only rise in a cycle where `fp_o` is 1.
- R4: `fp_o` is high for exactly one input-clock cycle per period.
- R5: N, A and the modulus select are captured only at the reload that starts a period. A change made during a period leaves that period's length unchanged and takes effect from the next period.
- R6: A main count of 0, 1 or 2 is treated as 3. In that case `ratio_err_o` is 1 for the whole period, and it returns to 0 at the first reload with a legal count. `ratio_err_o` changes only in a cycle where `fp_o` is 1.
- R7: While `rst_ni` is low, `fp_o`, `mod_ctl_o` and `ratio_err_o` are 0. The first reload happens on the first clock edge after reset is released, so `fp_o` is 1 in the first cycle after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock being divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| main_div_i | input | 11 | Main count N (3 to 2047; lower values are clamped) |
| swallow_i | input | 7 | Swallow count A (0 to 127, must be below N) |
| mod_sel_i | input | 1 | 1 selects M_LO/M_LO+1, 0 selects M_HI/M_HI+1 |
| fp_o | output | 1 | One-cycle pulse at each period boundary |
| mod_ctl_o | output | 1 | 1 while the prescaler divides by M+1 |
| ratio_err_o | output | 1 | Main count of the current period was below 3 |

## Verification
Each result is due at a fixed point relative to the reload edge. `fp_o` rises in the cycle right after the edge that reloads the counters. `ratio_err_o` and the first `mod_ctl_o` value change on that same edge, and the next `fp_o` rise comes exactly M·N + A cycles later. The bench drives new settings at the falling edge in which it sees `fp_o` high. It then measures one interval, which must still match the old setting, and a second interval, which must match the new one. While measuring, it counts `mod_ctl_o` high cycles and samples `ratio_err_o` at the first falling edge of the new period. The bench instance uses small moduli (4 and 8), so that N=2047 periods fit within the run time.

// File: rtl/psw_pkg.sv
package psw_pkg;
    localparam int MAIN_W   = 11;
    localparam int SWAL_W   = 7;
    localparam int MAIN_MIN = 3;

    typedef struct packed {
        logic [MAIN_W-1:0] main_div;
        logic [SWAL_W-1:0] swal;
        logic              sel_small;
        logic              err;
    } psw_cfg_t;

    typedef struct packed {
        logic [MAIN_W-1:0] mn;
        logic [SWAL_W-1:0] sw;
        logic              mc;
        logic              fp;
    } psw_cnt_t;
endpackage

// File: rtl/psw_cfg_reg.sv
module psw_cfg_reg
    import psw_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reload_i,
    input  logic [MAIN_W-1:0] main_div_i,
    input  logic [SWAL_W-1:0] swallow_i,
    input  logic              mod_sel_i,
    output psw_cfg_t          nxt_o,
    output psw_cfg_t          act_o
);
    psw_cfg_t cfg_d, cfg_q, clean;

    // Clamp the main count and build the candidate setting.
    always_comb begin
        clean.err       = (main_div_i < MAIN_W'(MAIN_MIN));
        clean.main_div  = clean.err ? MAIN_W'(MAIN_MIN) : main_div_i;
        clean.swal      = swallow_i;
        clean.sel_small = mod_sel_i;
        cfg_d           = reload_i ? clean : cfg_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign nxt_o = clean;
    assign act_o = cfg_q;
endmodule

// File: rtl/psw_prescaler.sv
module psw_prescaler #(
    parameter int M_LO = 64,
    parameter int M_HI = 128
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sel_small_i,
    input  logic plus_i,
    output logic tick_o
);
    localparam int PC_W = $clog2(M_HI + 1);

    logic [PC_W-1:0] pc_d, pc_q, load;

    // Load value M-1 gives M cycles; load value M gives M+1 cycles.
    always_comb begin
        if (sel_small_i) load = plus_i ? PC_W'(M_LO) : PC_W'(M_LO - 1);
        else             load = plus_i ? PC_W'(M_HI) : PC_W'(M_HI - 1);
        pc_d = tick_o ? load : pc_q - PC_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pc_q <= '0;
        else         pc_q <= pc_d;
    end

    assign tick_o = (pc_q == '0);
endmodule

// File: rtl/psw_swallow_ctl.sv
module psw_swallow_ctl
    import psw_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [MAIN_W-1:0] ld_main_i,
    input  logic [SWAL_W-1:0] ld_swal_i,
    output logic              reload_o,
    output logic              plus_next_o,
    output logic              fp_o,
    output logic              mod_ctl_o
);
    psw_cnt_t st_d, st_q;

    assign reload_o = tick_i && (st_q.mn <= MAIN_W'(1));

    always_comb begin
        st_d    = st_q;
        st_d.fp = 1'b0;
        if (tick_i) begin
            if (reload_o) begin
                st_d.mn = ld_main_i;
                st_d.sw = ld_swal_i;
                st_d.fp = 1'b1;
            end else begin
                st_d.mn = st_q.mn - MAIN_W'(1);
                st_d.sw = (st_q.sw != '0) ? st_q.sw - SWAL_W'(1) : '0;
            end
            st_d.mc = (st_d.sw != '0);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q    <= '0;
            st_q.mn <= MAIN_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign plus_next_o = st_d.mc;
    assign fp_o        = st_q.fp;
    assign mod_ctl_o   = st_q.mc;
endmodule

// File: rtl/psw_divider.sv
module psw_divider
    import psw_pkg::*;
#(
    parameter int M_LO = 64,
    parameter int M_HI = 128
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [MAIN_W-1:0] main_div_i,
    input  logic [SWAL_W-1:0] swallow_i,
    input  logic              mod_sel_i,
    output logic              fp_o,
    output logic              mod_ctl_o,
    output logic              ratio_err_o
);
    psw_cfg_t cfg_nxt, cfg_act;
    logic     tick, reload, plus_next, sel_eff;

    psw_cfg_reg u_cfg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .reload_i   (reload),
        .main_div_i (main_div_i),
        .swallow_i  (swallow_i),
        .mod_sel_i  (mod_sel_i),
        .nxt_o      (cfg_nxt),
        .act_o      (cfg_act)
    );

    // At a reload the new select governs the prescaler cycle that starts.
    assign sel_eff = reload ? cfg_nxt.sel_small : cfg_act.sel_small;

    psw_prescaler #(.M_LO(M_LO), .M_HI(M_HI)) u_pre (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sel_small_i (sel_eff),
        .plus_i      (plus_next),
        .tick_o      (tick)
    );

    psw_swallow_ctl u_ctl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick),
        .ld_main_i   (cfg_nxt.main_div),
        .ld_swal_i   (cfg_nxt.swal),
        .reload_o    (reload),
        .plus_next_o (plus_next),
        .fp_o        (fp_o),
        .mod_ctl_o   (mod_ctl_o)
    );

    assign ratio_err_o = cfg_act.err;
endmodule

// File: rtl/psw_divider_chk.sv
module psw_divider_chk
    import psw_pkg::*;
#(
    parameter int M_LO = 64,
    parameter int M_HI = 128
) (
    input logic clk_i,
    input logic rst_ni,
    input logic fp_o,
    input logic mod_ctl_o,
    input logic ratio_err_o
);
    localparam int MAX_P = M_HI * ((1 << MAIN_W) - 1) + (1 << SWAL_W) - 1;
    localparam int MIN_P = M_LO * MAIN_MIN;

    int   since_q;
    logic seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            since_q <= 0;
            seen_q  <= 1'b0;
        end else begin
            since_q <= fp_o ? 1 : since_q + 1;
            seen_q  <= seen_q | fp_o;
        end
    end

    a_r4_fp_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fp_o |=> !fp_o);

    a_r3_modctl_rises_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mod_ctl_o) |-> fp_o);

    a_r6_err_moves_at_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(ratio_err_o) |-> fp_o);

    a_r1_min_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fp_o && seen_q) |-> (since_q >= MIN_P));

    a_r1_max_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seen_q |-> (since_q <= MAX_P));
endmodule

bind psw_divider psw_divider_chk #(.M_LO(M_LO), .M_HI(M_HI)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fp_o        (fp_o),
    .mod_ctl_o   (mod_ctl_o),
    .ratio_err_o (ratio_err_o)
);

// File: tb/psw_divider_bench.sv
module psw_divider_bench;
    localparam int TB_LO = 4;
    localparam int TB_HI = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] main_div = 11'd3;
    logic [6:0]  swal = 7'd0;
    logic        sel = 1'b1;
    logic        fp, mctl, err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int old_n = 3, old_a = 0, old_s = 1;
    logic fp_prev = 1'b0;

    always #10 clk = ~clk;

    psw_divider #(.M_LO(TB_LO), .M_HI(TB_HI)) u_psw_divider (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .main_div_i  (main_div),
        .swallow_i   (swal),
        .mod_sel_i   (sel),
        .fp_o        (fp),
        .mod_ctl_o   (mctl),
        .ratio_err_o (err)
    );

    function automatic int exp_period(int n, int a, int s);
        int nn = (n < 3) ? 3 : n;
        return ((s != 0) ? TB_LO : TB_HI) * nn + a;
    endfunction

    function automatic int exp_modhi(int a, int s);
        return a * (((s != 0) ? TB_LO : TB_HI) + 1);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Measures one period; entered at a falling edge with fp high.
    task automatic run_period(output int len, output int hi);
        len = 0;
        hi  = 0;
        do begin
            hi  += int'(mctl);
            len++;
            @(negedge clk);
        end while (!fp);
    endtask

    task automatic apply(input int n, input int a, input int s);
        int len, hi;
        main_div = 11'(n);
        swal     = 7'(a);
        sel      = s[0];
        run_period(len, hi);
        check(len == exp_period(old_n, old_a, old_s), "R5 old period kept", len,
              exp_period(old_n, old_a, old_s));
        check(err == (n < 3), "R6 error flag", int'(err), int'(n < 3));
        run_period(len, hi);
        check(len == exp_period(n, a, s), "R1/R2 period M*N+A", len, exp_period(n, a, s));
        check(hi == exp_modhi(a, s), "R3 modulus-control cycles", hi, exp_modhi(a, s));
        old_n = n; old_a = a; old_s = s;
    endtask

    // R4 pulse width monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (fp && fp_prev) begin
                errors++;
                $display("FAIL R4 fp width: actual 2 expected 1");
            end
            if (fp_prev && !fp) checks++;
        end
        fp_prev = fp;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected below 190000", cycles);
            summary();
        end
    end

    initial begin
        void'($urandom(32'h0BAD5EED));
        repeat (3) @(negedge clk);
        check(fp == 1'b0, "R7 reset fp", int'(fp), 0);
        check(mctl == 1'b0, "R7 reset modctl", int'(mctl), 0);
        check(err == 1'b0, "R7 reset err", int'(err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(fp == 1'b1, "R7 first reload", int'(fp), 1);

        apply(3, 0, 1);
        apply(3, 2, 1);
        apply(3, 2, 0);
        apply(10, 9, 0);
        apply(40, 0, 1);
        apply(1, 0, 1);     // R6 clamp
        apply(0, 2, 0);     // R6 clamp
        apply(5, 4, 1);     // R6 clear
        apply(2047, 127, 1);
        apply(2047, 0, 0);
        apply(128, 127, 1); // A = N-1 at top of A range
        for (int i = 0; i < 12; i++) begin
            int n, a, s, amax;
            n    = 3 + $urandom_range(0, 297);
            amax = (n - 1 > 127) ? 127 : n - 1;
            a    = $urandom_range(0, amax);
            s    = $urandom_range(0, 1);
            apply(n, a, s);
        end
        summary();
    end
endmodule